// File: doc/BRIEF.md
# Serial I/Q Output Formatter

This block takes a finished pair of parallel result words, one in-phase (I) and one quadrature (Q), and sends them out bit by bit on two serial data lines. Each bit is held for a fixed number of system clocks (one bit period). A one-clock bit enable marks the start of every bit period, and a word strobe marks the first bit of every word. Bits go out most significant first. When no transfer is running, both data lines rest at logic zero.

Three formats can be chosen with each load. In simultaneous format the I word leaves on the I line while the Q word leaves on the Q line in parallel. In sequential format the whole I word leaves on the I line, followed at once by the whole Q word on the same line, and the Q line stays at zero. In real format a single word, presented on the I input, leaves on the I line and the Q line stays at zero. A load that arrives while a transfer is running is kept in a one-entry holding buffer and starts as soon as the running transfer ends.

Top module: `serial_iq_fmt`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `ser_i`, `ser_q`, `bit_en`, `word_strb` and `busy` are all 0.
- R2: A `load` sampled while idle starts a transfer whose first bit appears in the cycle right after that clock edge. Every bit is held for exactly `BIT_DIV` clocks, and bits go out most significant first.
- R3: Simultaneous format (`real_sel`=0, `seq_sel`=0): bit k of the transfer is `i_word[WORD_W-1-k]` on `ser_i` and `q_word[WORD_W-1-k]` on `ser_q`, for k from 0 to WORD_W-1.
- R4: Sequential format (`real_sel`=0, `seq_sel`=1): the transfer has 2*WORD_W bits. Bit k on `ser_i` is bit 2*WORD_W-1-k of the concatenation {i_word, q_word}, and `ser_q` stays 0.
- R5: Real format (`real_sel`=1, with `seq_sel` having no effect): the transfer has WORD_W bits taken from `i_word` on `ser_i`, and `ser_q` stays 0 even when `q_word` is not zero.
- R6: `word_strb` is 1 for every clock of the first bit period of each word: bit 0 in every format, and also bit WORD_W in sequential format. It is 0 at all other times.
- R7: `bit_en` is 1 in the first clock of each bit period of a transfer and 0 at all other times.
- R8: `busy` is 1 for every clock of a transfer. If nothing is waiting when the last bit period ends, `busy`, `ser_i` and `ser_q` are 0 in the next cycle.
- R9: A `load` sampled while busy stores the words and the format inputs into a one-entry buffer. A later load during the same transfer replaces the stored entry. The stored transfer begins in the first cycle after the current last bit, with no idle cycle in between. Format inputs that change during a transfer without a load do not affect it.
- R10: A `load` sampled at the same clock edge that ends a transfer, while the buffer is empty, starts its transfer directly in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Request to send the presented words |
| i_word | input | WORD_W | In-phase word, or the real word in real format |
| q_word | input | WORD_W | Quadrature word |
| seq_sel | input | 1 | 1: I word then Q word on `ser_i` |
| real_sel | input | 1 | 1: single real word on `ser_i` |
| ser_i | output | 1 | Serial I data line |
| ser_q | output | 1 | Serial Q data line |
| bit_en | output | 1 | One-clock pulse at the start of each bit period |
| word_strb | output | 1 | High for the first bit period of each word |
| busy | output | 1 | High for the whole transfer |

## Verification
The bench raises `load` on a falling edge, so the design captures it at the next rising edge, and the first bit is due one cycle after that edge. From then on, bit k occupies cycles k*BIT_DIV+1 through (k+1)*BIT_DIV after the capturing edge. The bench samples every output on each falling edge through the whole transfer and compares it with the value computed from that cycle index. The idle state is due in the cycle after the last bit. A buffered or same-edge load is due in that same cycle, so the bench goes straight on into the next expected stream with no gap cycle.

// File: rtl/serial_iq_fmt_pkg.sv
package serial_iq_fmt_pkg;

   typedef enum logic [1:0] {
      FMT_SIMUL = 2'd0,
      FMT_SEQ   = 2'd1,
      FMT_REAL  = 2'd2
   } fmt_mode_e;

   // real selection dominates the sequencing bit
   function automatic fmt_mode_e pick_mode(input logic seq_bit, input logic real_bit);
      if (real_bit)
         return FMT_REAL;
      else if (seq_bit)
         return FMT_SEQ;
      else
         return FMT_SIMUL;
   endfunction

endpackage

// File: rtl/iqf_bit_timer.sv
module iqf_bit_timer #(
   parameter int BIT_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic active,
   output logic at_last
);
   localparam int DIV_W = (BIT_DIV > 2) ? $clog2(BIT_DIV) : 1;
   localparam logic [DIV_W-1:0] TOP = DIV_W'(BIT_DIV - 1);

   if (BIT_DIV < 2) begin : g_bad_div
      $error("iqf_bit_timer: BIT_DIV must be at least 2");
   end

   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (restart)
         cnt <= '0;
      else if (active)
         cnt <= (cnt == TOP) ? '0 : cnt + 1'b1;
   end

   assign at_last = active && (cnt == TOP);

endmodule

// File: rtl/iqf_hold_buf.sv
module iqf_hold_buf
   import serial_iq_fmt_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [WORD_W-1:0] wr_i,
   input  logic [WORD_W-1:0] wr_q,
   input  fmt_mode_e         wr_mode,
   input  logic              rd,
   output logic              valid,
   output logic [WORD_W-1:0] rd_i,
   output logic [WORD_W-1:0] rd_q,
   output fmt_mode_e         rd_mode
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid   <= 1'b0;
         rd_i    <= '0;
         rd_q    <= '0;
         rd_mode <= FMT_SIMUL;
      end else if (wr) begin
         // a write wins over a same-cycle read: newest request kept
         valid   <= 1'b1;
         rd_i    <= wr_i;
         rd_q    <= wr_q;
         rd_mode <= wr_mode;
      end else if (rd) begin
         valid   <= 1'b0;
      end
   end

endmodule

// File: rtl/iqf_shift_lane.sv
module iqf_shift_lane #(
   parameter int LEN = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [LEN-1:0] load_val,
   input  logic           shift,
   input  logic           clear,
   output logic           msb
);
   if (LEN < 2) begin : g_bad_len
      $error("iqf_shift_lane: LEN must be at least 2");
   end

   logic [LEN-1:0] sh;

   always_ff @(posedge clk) begin
      if (!rst_n)
         sh <= '0;
      else if (load)
         sh <= load_val;
      else if (clear)
         sh <= '0;
      else if (shift)
         sh <= {sh[LEN-2:0], 1'b0};
   end

   assign msb = sh[LEN-1];

endmodule

// File: rtl/serial_iq_fmt.sv
module serial_iq_fmt
   import serial_iq_fmt_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter int BIT_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] i_word,
   input  logic [WORD_W-1:0] q_word,
   input  logic              seq_sel,
   input  logic              real_sel,
   output logic              ser_i,
   output logic              ser_q,
   output logic              bit_en,
   output logic              word_strb,
   output logic              busy
);
   localparam int IDX_W = $clog2(2 * WORD_W);
   localparam logic [IDX_W-1:0] LAST_ONE  = IDX_W'(WORD_W - 1);
   localparam logic [IDX_W-1:0] LAST_TWO  = IDX_W'(2 * WORD_W - 1);
   localparam logic [IDX_W-1:0] SECOND_W  = IDX_W'(WORD_W);

   if (WORD_W < 2) begin : g_bad_word
      $error("serial_iq_fmt: WORD_W must be at least 2");
   end

   logic             busy_q;
   logic [IDX_W-1:0] bit_idx;
   fmt_mode_e        mode_q;
   logic             bit_en_q;
   logic             t_last;

   logic             buf_valid;
   logic [WORD_W-1:0] buf_i, buf_q;
   fmt_mode_e        buf_mode;

   logic             end_xfer, advance, take_buf, start_new, start_any, buf_wr;
   logic [WORD_W-1:0] s_i, s_q;
   fmt_mode_e        s_mode, in_mode;
   logic [2*WORD_W-1:0] i_load_val;
   logic [WORD_W-1:0]   q_load_val;
   logic             lane_i_msb, lane_q_msb;

   assign in_mode   = pick_mode(seq_sel, real_sel);
   assign end_xfer  = busy_q && t_last &&
                      (bit_idx == ((mode_q == FMT_SEQ) ? LAST_TWO : LAST_ONE));
   assign advance   = busy_q && t_last && !end_xfer;
   assign take_buf  = end_xfer && buf_valid;
   assign start_new = load && (!busy_q || (end_xfer && !buf_valid));
   assign start_any = take_buf || start_new;
   assign buf_wr    = load && busy_q && !start_new;

   assign s_i    = take_buf ? buf_i    : i_word;
   assign s_q    = take_buf ? buf_q    : q_word;
   assign s_mode = take_buf ? buf_mode : in_mode;

   always_comb begin
      unique case (s_mode)
         FMT_SEQ: begin
            i_load_val = {s_i, s_q};
            q_load_val = '0;
         end
         FMT_REAL: begin
            i_load_val = {s_i, {WORD_W{1'b0}}};
            q_load_val = '0;
         end
         default: begin
            i_load_val = {s_i, {WORD_W{1'b0}}};
            q_load_val = s_q;
         end
      endcase
   end

   iqf_bit_timer #(.BIT_DIV(BIT_DIV)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (start_any),
      .active  (busy_q),
      .at_last (t_last)
   );

   iqf_hold_buf #(.WORD_W(WORD_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (buf_wr),
      .wr_i    (i_word),
      .wr_q    (q_word),
      .wr_mode (in_mode),
      .rd      (take_buf),
      .valid   (buf_valid),
      .rd_i    (buf_i),
      .rd_q    (buf_q),
      .rd_mode (buf_mode)
   );

   iqf_shift_lane #(.LEN(2 * WORD_W)) u_lane_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start_any),
      .load_val (i_load_val),
      .shift    (advance),
      .clear    (end_xfer),
      .msb      (lane_i_msb)
   );

   iqf_shift_lane #(.LEN(WORD_W)) u_lane_q (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start_any),
      .load_val (q_load_val),
      .shift    (advance),
      .clear    (end_xfer),
      .msb      (lane_q_msb)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         bit_idx  <= '0;
         mode_q   <= FMT_SIMUL;
         bit_en_q <= 1'b0;
      end else begin
         bit_en_q <= start_any || advance;
         if (start_any) begin
            busy_q  <= 1'b1;
            bit_idx <= '0;
            mode_q  <= s_mode;
         end else if (end_xfer) begin
            busy_q  <= 1'b0;
         end else if (advance) begin
            bit_idx <= bit_idx + 1'b1;
         end
      end
   end

   assign busy      = busy_q;
   assign bit_en    = bit_en_q;
   assign ser_i     = busy_q && lane_i_msb;
   assign ser_q     = busy_q && lane_q_msb;
   assign word_strb = busy_q &&
                      ((bit_idx == '0) || ((mode_q == FMT_SEQ) && (bit_idx == SECOND_W)));

   // R1 / R8: lines quiet whenever no transfer runs
   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ser_i && !ser_q && !word_strb && !bit_en));

   // R4 / R5: Q line silent outside simultaneous format
   a_r4_q_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && mode_q != FMT_SIMUL) |-> !ser_q);

   // R7: enable lasts one clock since BIT_DIV >= 2
   a_r7_bit_en_single: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en |=> !bit_en);

   // R2: data holds within a bit period
   a_r2_hold_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !bit_en) |-> ($stable(ser_i) && $stable(ser_q)));

   // R6: strobe rises only at a bit start
   a_r6_strobe_at_bit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(word_strb) |-> bit_en);

   // R9: buffer only fills during a transfer
   a_r9_buf_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      buf_valid |-> busy_q);

endmodule

// File: tb/serial_iq_fmt_tb.sv
module serial_iq_fmt_tb;
   localparam int W = 8;
   localparam int D = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic load = 1'b0;
   logic [W-1:0] i_word = '0, q_word = '0;
   logic seq_sel = 1'b0, real_sel = 1'b0;
   logic ser_i, ser_q, bit_en, word_strb, busy;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   int inj0_at = -1, inj1_at = -1;
   logic [W-1:0] inj0_i, inj0_q, inj1_i, inj1_q;
   logic inj0_seq, inj0_real, inj1_seq, inj1_real;

   always #4 clk = ~clk;

   serial_iq_fmt #(.WORD_W(W), .BIT_DIV(D)) u_dut (
      .clk(clk), .rst_n(rst_n), .load(load), .i_word(i_word), .q_word(q_word),
      .seq_sel(seq_sel), .real_sel(real_sel), .ser_i(ser_i), .ser_q(ser_q),
      .bit_en(bit_en), .word_strb(word_strb), .busy(busy)
   );

   task automatic chk(input logic got, input logic exp, input string tag);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: got %0b expected %0b", tag, $time, got, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   // presents a request on a falling edge
   task automatic request(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic sq, input logic rl);
      @(negedge clk);
      i_word = a; q_word = b; seq_sel = sq; real_sel = rl; load = 1'b1;
   endtask

   // checks a whole transfer, cycle by cycle, starting at the next falling edge
   task automatic expect_stream(input logic [W-1:0] a, input logic [W-1:0] b,
                                input logic sq, input logic rl);
      int nb;
      logic [2*W-1:0] cat;
      string tg;
      nb  = (!rl && sq) ? 2*W : W;
      cat = (!rl && sq) ? {a, b} : {a, {W{1'b0}}};
      tg  = rl ? "R5" : (sq ? "R4" : "R3");
      for (int k = 0; k < nb; k++) begin
         for (int c = 0; c < D; c++) begin
            int j;
            j = k*D + c;
            @(negedge clk);
            load = 1'b0;
            if (j == inj0_at) begin
               i_word = inj0_i; q_word = inj0_q; seq_sel = inj0_seq; real_sel = inj0_real; load = 1'b1;
            end else if (j == inj1_at) begin
               i_word = inj1_i; q_word = inj1_q; seq_sel = inj1_seq; real_sel = inj1_real; load = 1'b1;
            end else if (j == 4) begin
               // format inputs wiggle without a load: no effect (R9)
               seq_sel = ~seq_sel; real_sel = ~real_sel;
            end
            chk(ser_i, cat[2*W-1-k], {tg, " ser_i R2"});
            chk(ser_q, (!rl && !sq) ? b[W-1-k] : 1'b0, {tg, " ser_q"});
            chk(bit_en, c == 0, "R7 bit_en");
            chk(word_strb, (k == 0) || (!rl && sq && k == W), "R6 word_strb");
            chk(busy, 1'b1, "R8 busy");
         end
      end
   endtask

   task automatic expect_idle();
      @(negedge clk);
      load = 1'b0;
      chk(busy, 1'b0, "R8 busy after end");
      chk(ser_i, 1'b0, "R8 ser_i after end");
      chk(ser_q, 1'b0, "R8 ser_q after end");
      chk(word_strb, 1'b0, "R6 strobe idle");
      chk(bit_en, 1'b0, "R7 bit_en idle");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(busy, 1'b0, "R1 busy in reset");
      chk(ser_i, 1'b0, "R1 ser_i in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy, 1'b0, "R1 busy");
      chk(ser_i, 1'b0, "R1 ser_i");
      chk(ser_q, 1'b0, "R1 ser_q");
      chk(bit_en, 1'b0, "R1 bit_en");
      chk(word_strb, 1'b0, "R1 word_strb");

      // sweep all three formats over arithmetic patterns
      for (int m = 0; m < 4; m++) begin
         for (int v = 0; v < 12; v++) begin
            logic [W-1:0] a, b;
            a = W'(v * 37 + 1 + m);
            b = W'(~(v * 53) ^ (m * 11));
            request(a, b, m == 1, m >= 2);
            // m==3: real with seq set, seq must have no effect (R5)
            expect_stream(a, b, m == 1, m >= 2);
            expect_idle();
         end
      end

      // R9: two loads while busy, the later one wins, no gap
      inj0_at = 5;  inj0_i = 8'hA5; inj0_q = 8'h3C; inj0_seq = 1'b1; inj0_real = 1'b0;
      inj1_at = 10; inj1_i = 8'hC3; inj1_q = 8'hFF; inj1_seq = 1'b0; inj1_real = 1'b1;
      request(8'h96, 8'h69, 1'b0, 1'b0);
      expect_stream(8'h96, 8'h69, 1'b0, 1'b0);
      inj0_at = -1; inj1_at = -1;
      expect_stream(8'hC3, 8'hFF, 1'b0, 1'b1);
      expect_idle();

      // R9: buffered sequential transfer after a sequential one
      inj0_at = 20; inj0_i = 8'h81; inj0_q = 8'h7E; inj0_seq = 1'b1; inj0_real = 1'b0;
      request(8'h0F, 8'hF0, 1'b1, 1'b0);
      expect_stream(8'h0F, 8'hF0, 1'b1, 1'b0);
      inj0_at = -1;
      expect_stream(8'h81, 8'h7E, 1'b1, 1'b0);
      expect_idle();

      // R10: load on the last cycle of a transfer starts straight away
      inj0_at = 2*W*D - 1; inj0_i = 8'h5A; inj0_q = 8'hB4; inj0_seq = 1'b0; inj0_real = 1'b0;
      request(8'hE7, 8'h18, 1'b1, 1'b0);
      expect_stream(8'hE7, 8'h18, 1'b1, 1'b0);
      inj0_at = -1;
      expect_stream(8'h5A, 8'hB4, 1'b0, 1'b0);
      expect_idle();
      expect_idle();

      finish_run();
   end

endmodule